// File: doc/BRIEF.md
# Timed Erase-Then-Program Sequencer for a Serial EEPROM Core

This block turns a decoded programming request into a timed sequence of array writes. A command decoder presents the request as an operation code, a word address and a data word. It holds `req_valid` high once the instruction has been received in full. The sequencer acts on that request only when chip select falls and the write-enable latch is set. Each targeted word is first erased to all ones. If the operation carries data, the word is then programmed with that data. Each phase lasts a parameterised number of system clocks, which stands in for the cell programming time.

The single-word operations touch one address. The bulk operations walk every address from zero up to the last one. A `busy` output covers the whole sequence. Any new falling edge of chip select that arrives while `busy` is high is discarded. The memory array sits outside the block and is driven through a one-cycle write strobe with address and data.

Top module: `eeprom_prog_seq`

## Requirements
- R1: A sequence launches at the first clock edge where `cs` is low after being high on the previous edge, provided `req_valid`=1, `wen`=1 and `busy`=0; `busy` reads 1 from the next cycle.
- R2: `req_op` encoding: 0 programs one word with `req_data`, 1 erases one word, 2 programs every word with `req_data`, 3 erases every word.
- R3: For each word the erase phase lasts ERASE_CYCLES clocks, and its last cycle issues one array write of all ones to that word. For codes 0 and 2, a program phase of PROG_CYCLES clocks follows, and its last cycle writes the latched data to the same word.
- R4: Codes 2 and 3 ignore `req_addr` and process addresses 0,1,...,2^ADDR_W-1 in ascending order, one word after another with no idle cycle between them.
- R5: `busy` stays high for exactly N·(ERASE_CYCLES + P) cycles, where N is 1 or 2^ADDR_W and P is PROG_CYCLES for codes 0/2 or 0 for codes 1/3. `mem_we` is never 1 while `busy` is 0.
- R6: With `wen`=0 a falling edge of `cs` launches nothing: `busy` and `mem_we` stay 0.
- R7: A falling edge of `cs` on any edge where `busy` is 1 is dropped. This includes the final edge of a sequence. The running sequence continues unchanged and nothing starts after it.
- R8: With `req_valid`=0 a falling edge of `cs` launches nothing.
- R9: During and right after reset, `busy`=0 and `mem_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select level, synchronous to clk |
| req_valid | input | 1 | Decoder holds a complete programming instruction |
| req_op | input | 2 | Operation code (see R2) |
| req_addr | input | ADDR_W | Target word address for single-word codes |
| req_data | input | DATA_W | Data word for program codes |
| wen | input | 1 | Write-enable latch state |
| busy | output | 1 | Sequence in progress |
| mem_we | output | 1 | One-cycle array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
The two functions that can coincide are the completion of a running sequence and the launch detector seeing a new falling edge of chip select. The bench places a chip-select fall so that it lands on the very edge where the last array write retires and `busy` clears. The new request must be dropped: `busy` has to stay low afterwards and no further write may appear. A second fall in the middle of a sequence, with a different operation and address on the request inputs, must leave the stream of array writes identical to the one computed for the original request.

// File: rtl/eeprom_prog_pkg.sv
package eeprom_prog_pkg;

  typedef enum logic [1:0] {
    OP_WORD_PROG  = 2'd0,
    OP_WORD_ERASE = 2'd1,
    OP_ALL_PROG   = 2'd2,
    OP_ALL_ERASE  = 2'd3
  } prog_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ERASE = 2'd1,
    ST_PROG  = 2'd2
  } seq_state_e;

  // operation carries a program phase after the erase
  function automatic logic op_has_prog(input prog_op_e op);
    return (op == OP_WORD_PROG) || (op == OP_ALL_PROG);
  endfunction

  // operation walks the whole array
  function automatic logic op_is_bulk(input prog_op_e op);
    return op[1];
  endfunction

  // clocks spent on one word
  function automatic int word_cycles(input prog_op_e op, input int er, input int pr);
    return er + (op_has_prog(op) ? pr : 0);
  endfunction

endpackage

// File: rtl/eeprom_prog_launch.sv
module eeprom_prog_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic req_valid,
  input  logic wen,
  input  logic idle,
  output logic cs_fall,
  output logic launch
);
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b0;
    else        cs_q <= cs;
  end

  assign cs_fall = cs_q & ~cs;
  assign launch  = cs_fall & req_valid & wen & idle;

endmodule

// File: rtl/eeprom_prog_timer.sv
module eeprom_prog_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [CW-1:0] last,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = active && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!active || done) cnt <= '0;
    else                      cnt <= cnt + CW'(1);
  end

  // counter never runs past the phase length (R3)
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= last));

endmodule

// File: rtl/eeprom_prog_seq.sv
module eeprom_prog_seq
  import eeprom_prog_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 16,
  parameter int ERASE_CYCLES = 100,
  parameter int PROG_CYCLES  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              wen,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam logic [CW-1:0] ER_LAST = CW'(ERASE_CYCLES - 1);
  localparam logic [CW-1:0] PR_LAST = CW'(PROG_CYCLES - 1);

  seq_state_e        st;
  prog_op_e          cur_op;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_data;

  logic cs_fall, launch, phase_done;
  logic erase_commit, prog_commit, word_end, adv_word, finish;
  logic [CW-1:0] phase_last;

  eeprom_prog_launch u_launch (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .req_valid (req_valid),
    .wen       (wen),
    .idle      (st == ST_IDLE),
    .cs_fall   (cs_fall),
    .launch    (launch)
  );

  assign phase_last = (st == ST_PROG) ? PR_LAST : ER_LAST;

  eeprom_prog_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (st != ST_IDLE),
    .last   (phase_last),
    .done   (phase_done)
  );

  // named events
  assign erase_commit = (st == ST_ERASE) && phase_done;
  assign prog_commit  = (st == ST_PROG)  && phase_done;
  assign word_end     = prog_commit || (erase_commit && !op_has_prog(cur_op));
  assign adv_word     = word_end && op_is_bulk(cur_op) && (cur_addr != LAST_ADDR);
  assign finish       = word_end && !adv_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_op   <= OP_WORD_PROG;
      cur_addr <= '0;
      cur_data <= '0;
    end else begin
      if (launch) begin
        st       <= ST_ERASE;
        cur_op   <= prog_op_e'(req_op);
        cur_addr <= op_is_bulk(prog_op_e'(req_op)) ? '0 : req_addr;
        cur_data <= req_data;
      end else if (adv_word) begin
        st       <= ST_ERASE;
        cur_addr <= cur_addr + ADDR_W'(1);
      end else if (finish) begin
        st <= ST_IDLE;
      end else if (erase_commit) begin
        st <= ST_PROG;
      end
    end
  end

  assign busy      = (st != ST_IDLE);
  assign mem_we    = erase_commit || prog_commit;
  assign mem_addr  = cur_addr;
  assign mem_wdata = (st == ST_PROG) ? cur_data : {DATA_W{1'b1}};

  // assertion-only tracker: an erase must precede each program commit
  logic erase_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            erase_seen <= 1'b0;
    else if (erase_commit) erase_seen <= 1'b1;
    else if (prog_commit)  erase_seen <= 1'b0;
  end

  assert_launch_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  assert_prog_after_erase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_commit |-> erase_seen);

  assert_prog_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG && $past(st) == ST_PROG) |-> $stable(mem_addr));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adv_word |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  assert_we_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  assert_stay_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cs_fall && wen && req_valid)) |=> !busy);

  assert_drop_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs_fall) |=> ($stable(cur_op) && $stable(cur_data)));

endmodule

// File: tb/eeprom_prog_seq_tb.sv
module eeprom_prog_seq_tb;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int ER = 3;
  localparam int PR = 2;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, req_valid = 1'b0, wen = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  eeprom_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .ERASE_CYCLES(ER), .PROG_CYCLES(PR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .wen(wen), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  // run one request; cs falls at a negedge, launch edge follows
  task automatic run_op(input int op, input int addr, input int data,
                        input logic wen_v, input logic rv_v, input logic interfere);
    logic accept_exp;
    logic has_prog, bulk;
    int per, nwords, total;
    accept_exp = wen_v && rv_v;
    has_prog = (op == 0) || (op == 2);   // R2 encoding
    bulk     = (op >= 2);
    per      = ER + (has_prog ? PR : 0);
    nwords   = bulk ? NW : 1;
    total    = accept_exp ? nwords * per : 0;
    @(negedge clk);
    req_op = op[1:0]; req_addr = addr[AW-1:0]; req_data = data[DW-1:0];
    wen = wen_v; req_valid = rv_v; cs = 1'b1;
    @(negedge clk);
    cs = 1'b0;
    for (int n = 0; n < total + 6; n++) begin
      int j, k, eaddr, edata;
      logic ewe, ebusy;
      @(negedge clk);
      ebusy = (n < total);
      j = n / ((per > 0) ? per : 1);
      k = n % ((per > 0) ? per : 1);
      ewe = 1'b0; eaddr = 0; edata = 0;
      if (ebusy) begin
        eaddr = bulk ? j : addr;
        if (k == ER - 1) begin ewe = 1'b1; edata = (1 << DW) - 1; end
        else if (has_prog && k == ER + PR - 1) begin ewe = 1'b1; edata = data; end
      end
      if (!accept_exp)
        check(busy == 1'b0 && mem_we == 1'b0, wen_v ? "R8" : "R6", "no launch busy|we",
              int'({busy, mem_we}), 0);
      else if (n == 0)
        check(busy == 1'b1, "R1", "busy after launch", busy, 1);
      else
        check(busy == ebusy, interfere ? "R7" : "R5", "busy", busy, ebusy);
      check(mem_we == ewe, bulk ? "R4" : "R3", "mem_we", mem_we, ewe);
      if (ewe && mem_we) begin
        check(mem_addr == eaddr[AW-1:0], bulk ? "R4" : "R3", "mem_addr", mem_addr, eaddr);
        check(mem_wdata == edata[DW-1:0], "R2", "mem_wdata", mem_wdata, edata);
      end
      // interference: a mid-sequence fall with a different request (R7)
      if (interfere && accept_exp) begin
        if (n == 1) cs = 1'b1;
        if (n == 2) begin cs = 1'b0; req_op = ~op[1:0]; req_addr = ~addr[AW-1:0]; end
        if (n == total - 2) cs = 1'b1;
        if (n == total - 1) cs = 1'b0;   // falls on the finishing edge
      end
    end
    cs = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && mem_we == 1'b0, "R9", "reset busy|we", int'({busy, mem_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && mem_we == 1'b0, "R9", "post-reset busy|we", int'({busy, mem_we}), 0);
    // single-word sweep over all addresses
    for (int op = 0; op < 2; op++)
      for (int a = 0; a < NW; a++)
        run_op(op, a, (a * 37 + op * 11 + 5) & 8'hFF, 1'b1, 1'b1, (a % 3) == 1);
    // bulk ops with ignored address
    for (int op = 2; op < 4; op++) begin
      run_op(op, 5, 8'h5A, 1'b1, 1'b1, 1'b0);
      run_op(op, 2, 8'hC3, 1'b1, 1'b1, 1'b1);
    end
    // blocked requests
    for (int op = 0; op < 4; op++) begin
      run_op(op, op, 8'h0F, 1'b0, 1'b1, 1'b0);   // R6
      run_op(op, op, 8'hF0, 1'b1, 1'b0, 1'b0);   // R8
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule